// File: doc/BRIEF.md
# Write-Completion Status Read Path

This block models, one clock at a time, the read-data path of a nonvolatile byte store while an internal program or erase runs. A single-cycle start pulse marks the last bus write of a command sequence: the fourth write of a byte program or the sixth write of an erase. The pulse also gives the operation type and the byte being programmed. The block then counts a busy interval whose length is a parameter for each operation type. While busy, every read returns a status byte instead of stored data. Bit 7 carries a polarity flag, and bit 6 flips on every read. The host polls either bit to find out when the write has finished.

When the busy interval ends, the block does not return the full stored byte at once. For a settling window of SETTLE_CYCLES clocks, bit 7 already shows the true stored bit. Bits 6..0 stay frozen at the values they had when the operation completed. After that window, reads return the array byte unchanged. An erased location therefore reads FFh. The array, the analog write timing and the bus pads are not part of this block. The array byte is simply an input.

Top module: `wr_status_readback`

## Requirements
- R1: After reset, `rd_data` is 00h and `busy` is 0.
- R2: A start pulse while idle raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES clock cycles for a program (`op_is_erase`=0) or ERASE_CYCLES cycles for an erase (`op_is_erase`=1).
- R3: A read taken during a busy program returns bit 7 equal to the complement of bit 7 of the byte given with the start pulse.
- R4: A read taken during a busy erase returns bit 7 equal to 0.
- R5: During busy, bit 6 of successive reads alternates, and the first read after a start returns 0. The toggle advances only on a read strobe, never on clocks without one.
- R6: During busy, bits 5..0 of a read equal `array_q[5:0]` sampled at the strobe.
- R7: A start pulse while busy is ignored. The operation type, the target byte and the busy length are unchanged.
- R8: For SETTLE_CYCLES cycles after busy falls, a read returns bit 7 equal to `array_q[7]`. Bits 6..0 of that read are frozen:
  - bit 6 holds the value the toggle would have returned on the next busy read;
  - bits 5..0 hold `array_q[5:0]` as sampled in the last busy cycle.
  
  Two reads within this window therefore agree.
- R9: Outside busy and settling, a read returns `array_q` unchanged. An erased location (FFh) reads FFh.
- R10: `rd_data` is registered. It takes its new value at the clock edge that samples `rd_stb`=1 and holds its value when there is no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle pulse at the final write of a program or erase command |
| op_is_erase | input | 1 | Operation type with `op_start`: 1 = erase, 0 = program |
| op_byte | input | 8 | Byte being programmed, sampled with `op_start` |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| array_q | input | 8 | Current stored byte at the accessed location |
| rd_data | output | 8 | Registered read data or status byte |
| busy | output | 1 | Internal write in progress |

## Verification
A read result is due one cycle after its strobe: the byte appears at the rising edge that samples `rd_stb`. The monitor compares it at the falling edge that follows. `busy` is due on the cycle after an accepted start pulse. It is checked directly on the first and last expected busy cycles, and on the first expected idle cycle, counting from that start edge. The driver counts cycles from each start so that each expected status byte is computed for the phase it was read in: busy, settling or idle. The counted phases are matched to PROG_CYCLES, ERASE_CYCLES and SETTLE_CYCLES.

// File: rtl/wr_status_readback.sv
module wr_status_readback #(
  parameter int PROG_CYCLES   = 16,
  parameter int ERASE_CYCLES  = 40,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic       op_is_erase,
  input  logic [7:0] op_byte,
  input  logic       rd_stb,
  input  logic [7:0] array_q,
  output logic [7:0] rd_data,
  output logic       busy
);
  localparam int LONGEST = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW = $clog2(LONGEST + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 2);

  logic [CW-1:0] run_cnt;
  logic [SW-1:0] set_cnt;
  logic          kind_erase;
  logic [7:0]    tgt_byte;
  logic          tgl;
  logic [6:0]    hold;
  logic          settling, accept, last_busy;
  logic [7:0]    status_word, next_word;

  assign busy        = run_cnt != '0;
  assign settling    = set_cnt != '0;
  assign accept      = op_start && !busy;
  assign last_busy   = run_cnt == CW'(1);
  assign status_word = {kind_erase ? 1'b0 : ~tgt_byte[7], tgl, array_q[5:0]};
  assign next_word   = busy ? status_word : (settling ? {array_q[7], hold} : array_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt    <= '0;
      set_cnt    <= '0;
      kind_erase <= 1'b0;
      tgt_byte   <= '0;
      tgl        <= 1'b0;
      hold       <= '0;
    end else if (accept) begin
      run_cnt    <= op_is_erase ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
      kind_erase <= op_is_erase;
      tgt_byte   <= op_byte;
      tgl        <= 1'b0;
      set_cnt    <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt - CW'(1);
      if (rd_stb) tgl <= ~tgl;
      if (last_busy) begin
        set_cnt <= SW'(SETTLE_CYCLES);
        hold    <= {rd_stb ? ~tgl : tgl, array_q[5:0]};
      end
    end else if (settling) begin
      set_cnt <= set_cnt - SW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= next_word;
  end

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_prog_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && !kind_erase) |=> rd_data[7] == !$past(tgt_byte[7]));
  assert_erase_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && busy && kind_erase) |=> !rd_data[7]);
  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((tgl != $past(tgl)) == $past(rd_stb)));
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_start) |=> ($stable(kind_erase) && $stable(tgt_byte)));
  assert_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && rd_stb) |=> rd_data[6:0] == $past(hold));
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !settling && rd_stb) |=> rd_data == $past(array_q));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/sim_wr_status_readback.sv
module sim_wr_status_readback;
  localparam int NP = 6, NE = 10, NS = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_start = 1'b0, op_is_erase = 1'b0, rd_stb = 1'b0;
  logic [7:0] op_byte = '0, array_q = '0;
  logic [7:0] rd_data;
  logic busy;

  int applied = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic due = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wr_status_readback #(.PROG_CYCLES(NP), .ERASE_CYCLES(NE), .SETTLE_CYCLES(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
    .op_byte(op_byte), .rd_stb(rd_stb), .array_q(array_q), .rd_data(rd_data), .busy(busy));

  always @(posedge clk) due <= rd_stb;

  always @(negedge clk) begin
    if (due) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      applied++;
      if (rd_data !== e) begin
        bad++;
        $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
      end
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string t);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] arr, input logic [7:0] exp, input string t);
    array_q = arr;
    rd_stb = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(t);
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic idle(input logic [7:0] arr);
    array_q = arr;
    @(negedge clk);
  endtask

  task automatic start(input logic e, input logic [7:0] b);
    op_start = 1'b1;
    op_is_erase = e;
    op_byte = b;
    @(negedge clk);
    op_start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(rd_data, 8'h00, "R1 reset data");
    check({7'd0, busy}, 8'h00, "R1 reset busy");
    rd(8'h3C, 8'h3C, "R9 idle read");

    // program 5Ah: bit7 reads 1 while busy
    start(1'b0, 8'h5A);
    check({7'd0, busy}, 8'h01, "R2 busy after start");
    rd(8'h81, 8'h81, "R3 R5 R6 first program read");     // k0
    rd(8'h81, 8'hC1, "R5 toggled read");                 // k1
    idle(8'h92);                                          // k2
    check(rd_data, 8'hC1, "R10 hold without strobe");
    rd(8'h92, 8'h92, "R5 R6 no advance on idle clock");  // k3
    start(1'b1, 8'h00);                                   // k4, ignored
    check({7'd0, busy}, 8'h01, "R2 last program busy cycle");
    rd(8'h80, 8'hC0, "R7 still program status");         // k5
    check({7'd0, busy}, 8'h00, "R2 R7 busy length");
    rd(8'h5A, 8'h00, "R8 settle read");                   // k6
    rd(8'h5A, 8'h00, "R8 settle repeat");                 // k7
    idle(8'h5A);                                          // k8
    rd(8'h5A, 8'h5A, "R9 true data after settle");       // k9

    // erase
    start(1'b1, 8'h00);
    rd(8'h7F, 8'h3F, "R4 R5 first erase read");          // k0
    rd(8'h7F, 8'h7F, "R4 R5 erase toggle");              // k1
    for (int i = 2; i < NE - 1; i++) idle(8'hFF);
    check({7'd0, busy}, 8'h01, "R2 last erase busy cycle");
    rd(8'hFF, 8'h3F, "R4 R6 last erase read");           // k9
    check({7'd0, busy}, 8'h00, "R2 erase length");
    rd(8'hC0, 8'hFF, "R8 erase settle frozen bits");     // k10
    idle(8'hFF);
    idle(8'hFF);
    rd(8'hFF, 8'hFF, "R9 erased reads FFh");

    // program A5h: bit7 reads 0 while busy
    start(1'b0, 8'hA5);
    rd(8'hFF, 8'h3F, "R3 complement of 1");
    for (int i = 0; i < NP + NS + 1; i++) idle(8'hA5);
    rd(8'hA5, 8'hA5, "R9 final idle read");
    idle(8'hA5);
    idle(8'hA5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule